// File: doc/BRIEF.md
# Rounding and packing unit

This block is the last step of a floating-point datapath. It receives an already normalized operand in pieces: a sign, a biased exponent, the fraction bits that fall below the hidden one, and an extended tail of lower-order bits. It applies one of four rounding modes and writes the result as a packed IEEE-style word. The mode comes from the two top bits of an 8-bit control byte.

When rounding carries out of the significand, the block renormalizes the result and raises the exponent by one. When the exponent then reaches all ones, it reports overflow and emits a correctly signed infinity. An incoming flag vector passes through to the output. The overflow bit is merged with the block's own overflow, and an active-low silent bit in the control byte masks the invalid-operation flag.

A one-cycle start strobe launches an operation. The block walks through three named states: `ST_IDLE` → `ST_ROUND` → `ST_PACK` → `ST_IDLE`.
- In `ST_IDLE` it waits. A start strobe captures the operands and takes it to `ST_ROUND`.
- In `ST_ROUND` it forms the rounded significand, then always moves to `ST_PACK`.
- In `ST_PACK` it registers the packed word and the flags, then always returns to `ST_IDLE`.

Result and flags appear together with a one-cycle done pulse.

Top module: `rnd_pack_unit`

## Requirements
- R1: Mode 00 in ctrl_i[7:6] (nearest, ties away) adds one unit in the last place whenever the guard bit is 1.
- R2: Mode 01 (nearest even) adds one unit in the last place when guard is 1 and at least one of round, sticky or the fraction LSB is 1.
- R3: Mode 10 (toward plus infinity) adds one unit in the last place when the sign is 0 and any of guard, round or sticky is 1. A negative value is left unchanged.
- R4: Mode 11 (truncate) never changes the fraction.
- R5: tail_i[TAIL_W-1] is the guard bit and tail_i[TAIL_W-2] is the round bit. The OR of tail_i[TAIL_W-3:0] is the sticky bit.
- R6: A carry out of the hidden-one significand clears the output fraction and adds one to the exponent.
- R7: A final exponent that reaches all ones produces an infinity: exponent all ones, fraction zero, sign kept. It also sets flag bit 1 (overflow).
- R8: Flag bit 0 (invalid) is output only when ctrl_i[5] was 1 at start. Flag bit 2 passes through. Flag bit 1 is the OR of the incoming overflow bit and the block's own overflow.
- R9: An accepted start sampled at clock edge k gives result, flags and done_o=1 after edge k+2, and done_o is 0 in the following cycle.
- R10: A start that arrives while an operation is in progress is ignored.
- R11: The packed word carries the sign in its top bit, then EXP_W exponent bits, then FRAC_W fraction bits at the bottom.
- R12: After reset, result_o, flags_o and done_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; captures all operand inputs |
| sign_i | input | 1 | Sign of the operand |
| exp_i | input | EXP_W (11) | Biased exponent |
| frac_i | input | FRAC_W (52) | Fraction below the hidden one |
| tail_i | input | TAIL_W (53) | Lower-order bits: guard, round, then sticky source |
| ctrl_i | input | 8 | [7:6] rounding mode, [5] silent (active low), [4:0] reserved |
| flags_i | input | 3 | Incoming flags: [0] invalid, [1] overflow, [2] underflow |
| result_o | output | 1+EXP_W+FRAC_W (64) | Packed result |
| flags_o | output | 3 | Final flags, same bit order as flags_i |
| done_o | output | 1 | One-cycle pulse marking valid result and flags |

## Verification
The bench builds the unit with a 4-bit exponent, a 3-bit fraction and a 4-bit tail. That shrinks the operand space so every fraction, every tail pattern, both signs and all four modes can be swept exhaustively. The sweep runs at a low, a middle and the highest finite exponent. At the highest exponent, every carry from rounding leads into the overflow-to-infinity path, so that path is exercised many times rather than only at one corner. Directed runs add a start issued while busy, the reset state and explicit field-position checks.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    localparam int CTRL_W  = 8;
    localparam int FLAG_W  = 3;
    localparam int FLG_INV = 0;
    localparam int FLG_OVF = 1;
    localparam int FLG_UFL = 2;
    localparam int CTRL_SILENT_N = 5;

    typedef enum logic [1:0] {
        RM_NEAR      = 2'b00,
        RM_NEAR_EVEN = 2'b01,
        RM_POS_INF   = 2'b10,
        RM_TRUNC     = 2'b11
    } rmode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_PACK  = 2'd2
    } rstate_t;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
#(
    parameter int TAIL_W = 53
) (
    input  rmode_t              mode,
    input  logic                sign,
    input  logic                lsb,
    input  logic [TAIL_W-1:0]   tail,
    output logic                inc
);
    logic guard_b;
    logic round_b;
    logic sticky_b;

    // R5: guard is the first bit below the fraction, round the second
    assign guard_b = tail[TAIL_W-1];
    assign round_b = tail[TAIL_W-2];

    generate
        if (TAIL_W > 2) begin : g_sticky
            assign sticky_b = |tail[TAIL_W-3:0];
        end else begin : g_nosticky
            assign sticky_b = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            RM_NEAR:      inc = guard_b;                                   // R1
            RM_NEAR_EVEN: inc = guard_b & (round_b | sticky_b | lsb);      // R2
            RM_POS_INF:   inc = ~sign & (guard_b | round_b | sticky_b);    // R3
            RM_TRUNC:     inc = 1'b0;                                      // R4
            default:      inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int SIG_W = 53
) (
    input  logic [SIG_W-1:0] sig,
    input  logic             inc,
    output logic [SIG_W:0]   sum
);
    assign sum = {1'b0, sig} + {{SIG_W{1'b0}}, inc};
endmodule

// File: rtl/rnd_pack.sv
module rnd_pack #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic              carry,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [WORD_W-1:0] word,
    output logic              ovf
);
    localparam logic [EXP_W:0] EXP_TOP = {1'b0, {EXP_W{1'b1}}};

    logic [EXP_W:0]  exp_n;
    logic [FRAC_W-1:0] frac_n;

    // R6: carry renormalizes to 1.000... and bumps the exponent
    assign exp_n  = {1'b0, exp_in} + {{EXP_W{1'b0}}, carry};
    assign frac_n = carry ? {FRAC_W{1'b0}} : frac_in;
    // R7: reaching the all-ones exponent is overflow
    assign ovf    = (exp_n >= EXP_TOP);

    always_comb begin
        if (ovf) begin
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            word = {sign, exp_n[EXP_W-1:0], frac_n};   // R11
        end
    end
endmodule

// File: rtl/rnd_pack_unit.sv
module rnd_pack_unit
    import rnd_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int TAIL_W = 53,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [TAIL_W-1:0] tail_i,
    input  logic [7:0]        ctrl_i,
    input  logic [2:0]        flags_i,
    output logic [WORD_W-1:0] result_o,
    output logic [2:0]        flags_o,
    output logic              done_o
);
    rstate_t st_q, st_d;

    logic              sign_q;
    logic [EXP_W-1:0]  exp_q;
    logic [FRAC_W-1:0] frac_q;
    logic [TAIL_W-1:0] tail_q;
    rmode_t            mode_q;
    logic              silent_n_q;
    logic [FLAG_W-1:0] flg_q;
    logic [SIG_W:0]    sum_q;

    logic              inc_w;
    logic [SIG_W:0]    sum_w;
    logic [WORD_W-1:0] word_w;
    logic              ovf_w;
    logic              ctrl_unused;

    assign ctrl_unused = ^ctrl_i[CTRL_SILENT_N-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  st_d = start_i ? ST_ROUND : ST_IDLE;   // R10: only here is start seen
            ST_ROUND: st_d = ST_PACK;
            ST_PACK:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    rnd_decide #(.TAIL_W(TAIL_W)) decide_i (
        .mode (mode_q),
        .sign (sign_q),
        .lsb  (frac_q[0]),
        .tail (tail_q),
        .inc  (inc_w)
    );

    rnd_incr #(.SIG_W(SIG_W)) incr_i (
        .sig ({1'b1, frac_q}),
        .inc (inc_w),
        .sum (sum_w)
    );

    rnd_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) pack_i (
        .sign    (sign_q),
        .exp_in  (exp_q),
        .carry   (sum_q[SIG_W]),
        .frac_in (sum_q[FRAC_W-1:0]),
        .word    (word_w),
        .ovf     (ovf_w)
    );

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q     <= 1'b0;
            exp_q      <= '0;
            frac_q     <= '0;
            tail_q     <= '0;
            mode_q     <= RM_NEAR;
            silent_n_q <= 1'b0;
            flg_q      <= '0;
            sum_q      <= '0;
            result_o   <= '0;
            flags_o    <= '0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        sign_q     <= sign_i;
                        exp_q      <= exp_i;
                        frac_q     <= frac_i;
                        tail_q     <= tail_i;
                        mode_q     <= rmode_t'(ctrl_i[CTRL_W-1 -: 2]);
                        silent_n_q <= ctrl_i[CTRL_SILENT_N];
                        flg_q      <= flags_i;
                    end
                end
                ST_ROUND: begin
                    sum_q <= sum_w;
                end
                ST_PACK: begin
                    result_o         <= word_w;
                    flags_o[FLG_INV] <= flg_q[FLG_INV] & silent_n_q;   // R8
                    flags_o[FLG_OVF] <= flg_q[FLG_OVF] | ovf_w;        // R7
                    flags_o[FLG_UFL] <= flg_q[FLG_UFL];
                    done_o           <= 1'b1;                          // R9
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rnd_pack_unit_chk.sv
module rnd_pack_unit_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [7:0]        ctrl_i,
    input logic [WORD_W-1:0] result_o,
    input logic [2:0]        flags_o,
    input logic              done_o
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 3));

    p_overflow_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (&result_o[WORD_W-2 -: EXP_W])) |->
            (result_o[FRAC_W-1:0] == '0) && flags_o[1]);

    p_silent_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(ctrl_i[5], 3)) |-> !flags_o[0]);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(flags_o)));
endmodule

bind rnd_pack_unit rnd_pack_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ctrl_i   (ctrl_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .done_o   (done_o)
);

// File: tb/rnd_pack_unit_tb_top.sv
module rnd_pack_unit_tb_top;
    localparam int EW = 4;
    localparam int FW = 3;
    localparam int TW = 4;
    localparam int WW = 1 + EW + FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          sign_i = 1'b0;
    logic [EW-1:0] exp_i = '0;
    logic [FW-1:0] frac_i = '0;
    logic [TW-1:0] tail_i = '0;
    logic [7:0]    ctrl_i = '0;
    logic [2:0]    flags_i = '0;
    logic [WW-1:0] result_o;
    logic [2:0]    flags_o;
    logic          done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rnd_pack_unit #(.EXP_W(EW), .FRAC_W(FW), .TAIL_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sign_i(sign_i),
        .exp_i(exp_i), .frac_i(frac_i), .tail_i(tail_i), .ctrl_i(ctrl_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o), .done_o(done_o)
    );

    // reference: {word, flags}
    function automatic logic [WW+2:0] model(input logic s, input logic [EW-1:0] e,
        input logic [FW-1:0] f, input logic [TW-1:0] t, input logic [1:0] m,
        input logic sil_n, input logic [2:0] fl);
        int sig, g, r, st, inc, ex, fo, ov;
        sig = (1 << FW) + f;
        g = t[TW-1]; r = t[TW-2]; st = (t[TW-3:0] != 0) ? 1 : 0;   // R5
        case (m)
            2'b00: inc = g;                                          // R1
            2'b01: inc = g & (r | st | (f & 1));                     // R2
            2'b10: inc = (s == 0) ? (g | r | st) : 0;                // R3
            default: inc = 0;                                        // R4
        endcase
        sig = sig + inc;
        ex = e; fo = sig % (1 << FW);
        if (sig >= (2 << FW)) begin ex = ex + 1; fo = 0; end         // R6
        ov = (ex >= (1 << EW) - 1) ? 1 : 0;
        if (ov != 0) begin ex = (1 << EW) - 1; fo = 0; end           // R7
        model = {s, ex[EW-1:0], fo[FW-1:0],
                 fl[2], fl[1] | ov[0], fl[0] & sil_n};               // R8, R11
    endfunction

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00: tag_of = "R1";
            2'b01: tag_of = "R2";
            2'b10: tag_of = "R3";
            default: tag_of = "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [WW+2:0] exp_v, input logic exp_done);
        n_chk++;
        if ({result_o, flags_o} !== exp_v || done_o !== exp_done) begin
            n_bad++;
            $display("FAIL %s: got result %h flags %b done %b, expected result %h flags %b done %b",
                     tag, result_o, flags_o, done_o, exp_v[WW+2:3], exp_v[2:0], exp_done);
        end
    endtask

    task automatic run_one(input string tag, input logic s, input logic [EW-1:0] e,
        input logic [FW-1:0] f, input logic [TW-1:0] t, input logic [1:0] m,
        input logic sil_n, input logic [2:0] fl);
        logic [WW+2:0] ev;
        ev = model(s, e, f, t, m, sil_n, fl);
        @(negedge clk);
        start_i = 1'b1; sign_i = s; exp_i = e; frac_i = f; tail_i = t;
        ctrl_i = {m, sil_n, 5'b10110}; flags_i = fl;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tag, ev, 1'b1);                       // R9 timing
        @(negedge clk);
        check("R9", ev, 1'b0);                      // pulse ends, result held
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12", '0, 1'b0);
        rst_n = 1'b1;

        // R11: field placement, truncate, negative value
        run_one("R11", 1'b1, 4'd9, 3'd5, 4'b0000, 2'b11, 1'b1, 3'b000);
        // R5: only sticky set: even keeps, plus-inf bumps
        run_one("R5", 1'b0, 4'd9, 3'd2, 4'b0001, 2'b01, 1'b1, 3'b000);
        run_one("R5", 1'b0, 4'd9, 3'd2, 4'b0001, 2'b10, 1'b1, 3'b000);
        // R6: carry out of all-ones fraction
        run_one("R6", 1'b0, 4'd9, 3'd7, 4'b1000, 2'b00, 1'b1, 3'b000);
        // R7: carry at max finite exponent
        run_one("R7", 1'b1, 4'd14, 3'd7, 4'b1000, 2'b00, 1'b1, 3'b000);
        // R8: silent masks invalid
        run_one("R8", 1'b0, 4'd5, 3'd1, 4'b0000, 2'b11, 1'b0, 3'b111);
        run_one("R8", 1'b0, 4'd5, 3'd1, 4'b0000, 2'b11, 1'b1, 3'b101);

        // R10: second start while busy is ignored
        begin
            logic [WW+2:0] ev;
            ev = model(1'b0, 4'd3, 3'd4, 4'b1100, 2'b00, 1'b1, 3'b000);
            @(negedge clk);
            start_i = 1'b1; sign_i = 1'b0; exp_i = 4'd3; frac_i = 3'd4; tail_i = 4'b1100;
            ctrl_i = 8'b00100000; flags_i = 3'b000;
            @(negedge clk);
            sign_i = 1'b1; exp_i = 4'd12; frac_i = 3'd1; tail_i = 4'b0000;
            ctrl_i = 8'b11000000; flags_i = 3'b111;
            @(negedge clk); start_i = 1'b0;
            @(negedge clk);
            check("R10", ev, 1'b1);
            @(negedge clk);
            check("R10", ev, 1'b0);
            @(negedge clk);
            check("R10", ev, 1'b0);
        end

        // exhaustive sweep over the small configuration
        for (int ei = 0; ei < 3; ei++) begin
            for (int s = 0; s < 2; s++) begin
                for (int f = 0; f < 8; f++) begin
                    for (int t = 0; t < 16; t++) begin
                        for (int m = 0; m < 4; m++) begin
                            logic [EW-1:0] e;
                            logic [FW-1:0] fv;
                            logic [TW-1:0] tv;
                            logic [1:0]    mv;
                            e  = (ei == 0) ? 4'd1 : (ei == 1) ? 4'd9 : 4'd14;
                            fv = f[FW-1:0];
                            tv = t[TW-1:0];
                            mv = m[1:0];
                            run_one(tag_of(mv), s[0], e, fv, tv, mv,
                                    fv[0] ^ tv[1], tv[2:0] ^ fv);
                        end
                    end
                end
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule